// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32.768 kHz time-base strobe into a programmable periodic tick for a real-time-clock style interrupt unit. A 4-bit rate code selects a power-of-two period, counted in time-base strobes. Each tick becomes a one-cycle periodic-event strobe toward the interrupt flag logic, a one-cycle square-wave pulse, or both, depending on which of the two enables is set. The flag storage itself sits outside this block.

Ticks are not counted from the moment the rate code is written. A free-running time-base counter advances once per strobe and is never cleared by a rate change or by toggling an enable. A tick falls on each strobe that brings that counter to a whole multiple of the selected period. A new rate code therefore takes effect at the next boundary of the new period on the shared count. The two fastest codes are aliased to slow rates, so the shortest period the block can produce is four strobes.

Top module: `ppi_divider`

## Requirements
- R1: While `rst` is high on a clock edge, the time-base counter is cleared to zero and both outputs are low in the next cycle.
- R2: Rate code 0 stops the tick: neither output ever pulses while `rate_sel` is 0, whatever the enables.
- R3: For a rate code n from 3 to 15, the period is 2^(n-1) time-base strobes (code 3 gives 4, code 15 gives 16384).
- R4: Codes 1 and 2 are aliased to 2^7 = 128 and 2^8 = 256 strobes, as if 7 were added to the code.
- R5: With both `pie_en` and `sqw_en` low, no output pulses, but the free-running counter keeps advancing on every strobe.
- R6: `pf_evt` pulses on a tick only while `pie_en` is high.
- R7: `sqw_pulse` pulses on a tick only while `sqw_en` is high and the parameter `HAS_SQW` is 1. It is a one-cycle pulse, not a 50% duty waveform.
- R8: A tick falls on the strobe that makes the free-running count a multiple of the period. The count is not reset by rate or enable changes, so a new code takes effect at the next aligned boundary of its own period.
- R9: The outputs are registered. A pulse appears in the cycle after the clock edge that samples the strobe and lasts one cycle. Cycles without a strobe produce no pulse and do not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| rate_sel | input | 4 | Rate code; 0 stops the tick |
| pie_en | input | 1 | Periodic-event enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| pf_evt | output | 1 | One-cycle periodic-event strobe to the interrupt flag logic |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
The hardest case to reach from the ports is a rate change made while the free-running count is not aligned to either period. The stimulus first runs code 8 for a number of strobes that leaves the count mid-period, then switches to code 3. It also passes through stretches with both enables off. This shows that the first new tick lands on the shared count's boundary and not a full period after the write. The slowest code needs 16384 strobes to reach a single boundary. To make that feasible, the bench drives a strobe on every clock in that phase, and it uses strobes with idle gaps elsewhere to check that only strobes advance the count.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  localparam int RATE_W    = 4;
  localparam int ALIAS_ADD = 7;
  localparam int ALIAS_MAX = 2;
  localparam int MAX_SHIFT = (1 << RATE_W) - 2;
  localparam int CNT_W     = MAX_SHIFT + 1;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  typedef logic [RATE_W-1:0]  rate_t;
  typedef logic [SHIFT_W-1:0] shift_t;
  typedef logic [CNT_W-1:0]   tcount_t;

  typedef struct packed {
    logic  pie;
    logic  sqwe;
    rate_t rate;
  } ppi_cfg_t;

  // Period exponent for a nonzero rate code; the two fastest codes are aliased.
  function automatic shift_t rate_to_shift(input rate_t code);
    logic [RATE_W:0] eff;
    if (code == '0) begin
      return '0;
    end
    if (int'(code) <= ALIAS_MAX) begin
      eff = {1'b0, code} + (RATE_W+1)'(ALIAS_ADD);
    end else begin
      eff = {1'b0, code};
    end
    return shift_t'(eff - (RATE_W+1)'(1));
  endfunction

endpackage

// File: rtl/ppi_timebase_cnt.sv
module ppi_timebase_cnt #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next
);

  assign cnt_next = cnt + W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= cnt_next;
    end
  end

  // R8: the count advances by exactly one per strobe, never jumps or clears
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cnt == $past(cnt) + W'(1)));

  // R9: without a strobe the count holds
  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));

endmodule

// File: rtl/ppi_rate_decode.sv
module ppi_rate_decode
  import ppi_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  rate_t        rate,
  output logic         rate_on,
  output logic [W-1:0] low_mask
);

  shift_t shamt;

  assign shamt   = rate_to_shift(rate);
  assign rate_on = (rate != '0);

  // One mask bit per count bit: set for every bit below the period exponent.
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign low_mask[i] = rate_on && (int'(shamt) > i);
  end

endmodule

// File: rtl/ppi_tick_detect.sv
module ppi_tick_detect #(
  parameter int W = 15
) (
  input  logic         adv,
  input  logic         run,
  input  logic [W-1:0] cnt_next,
  input  logic [W-1:0] low_mask,
  output logic         tick
);

  logic aligned;

  assign aligned = ((cnt_next & low_mask) == '0);
  assign tick    = adv && run && aligned;

endmodule

// File: rtl/ppi_divider.sv
module ppi_divider
  import ppi_pkg::*;
#(
  parameter bit HAS_SQW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              pf_evt,
  output logic              sqw_pulse
);

  ppi_cfg_t cfg;
  tcount_t  cnt, cnt_next, low_mask;
  logic     rate_on, run, tick, sqw_gate;

  assign cfg.pie  = pie_en;
  assign cfg.sqwe = sqw_en;
  assign cfg.rate = rate_sel;

  ppi_timebase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .adv      (tb_tick),
    .cnt      (cnt),
    .cnt_next (cnt_next)
  );

  ppi_rate_decode #(.W(CNT_W)) u_dec (
    .rate     (cfg.rate),
    .rate_on  (rate_on),
    .low_mask (low_mask)
  );

  if (HAS_SQW) begin : g_sqw
    assign sqw_gate = cfg.sqwe;
  end else begin : g_nosqw
    assign sqw_gate = 1'b0;
  end

  assign run = rate_on && (cfg.pie || sqw_gate);

  ppi_tick_detect #(.W(CNT_W)) u_det (
    .adv      (tb_tick),
    .run      (run),
    .cnt_next (cnt_next),
    .low_mask (low_mask),
    .tick     (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_evt    <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      pf_evt    <= tick && cfg.pie;
      sqw_pulse <= tick && sqw_gate;
    end
  end

  // R1: reset leaves both outputs low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pf_evt && !sqw_pulse));

  // R2: code zero never produces a pulse
  a_r2_code_zero: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0) |=> (!pf_evt && !sqw_pulse));

  // R6: periodic event needs its enable
  a_r6_pie_gate: assert property (@(posedge clk) disable iff (rst)
    !pie_en |=> !pf_evt);

  // R7: square-wave pulse needs its enable
  a_r7_sqw_gate: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw_pulse);

  // R9: pulses only follow a strobe and never last two cycles (shortest period is 4)
  a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !tb_tick |=> (!pf_evt && !sqw_pulse));

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    pf_evt |=> !pf_evt);

endmodule

// File: tb/ppi_divider_test.sv
module ppi_divider_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       pf_evt, sqw_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic  pf;
    logic  sq;
    string req;
  } exp_t;

  exp_t exp_q[$];
  logic [14:0] mcnt = '0;

  always #2 clk = ~clk;

  ppi_divider uut (
    .clk       (clk),
    .rst       (rst),
    .tb_tick   (tb_tick),
    .rate_sel  (rate_sel),
    .pie_en    (pie_en),
    .sqw_en    (sqw_en),
    .pf_evt    (pf_evt),
    .sqw_pulse (sqw_pulse)
  );

  function automatic int period_of(input logic [3:0] code);
    int n;
    n = int'(code);
    if (n <= 2) n = n + 7;
    return 1 << (n - 1);
  endfunction

  // Driver: one cycle of stimulus, pushes the expected outputs for the next cycle
  task automatic drive_cycle(input logic [3:0] code, input logic pie, input logic sqe,
                             input logic stb, input string req);
    exp_t e;
    logic tk;
    @(negedge clk);
    rate_sel = code;
    pie_en   = pie;
    sqw_en   = sqe;
    tb_tick  = stb;
    tk = 1'b0;
    if (stb) begin
      mcnt = mcnt + 15'd1;
      if (code != 4'd0 && (pie || sqe))
        tk = ((int'(mcnt) % period_of(code)) == 0);
    end
    e.pf  = tk && pie;
    e.sq  = tk && sqe;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic run(input logic [3:0] code, input logic pie, input logic sqe,
                     input int strobes, input int gap, input string req);
    for (int i = 0; i < strobes; i++) begin
      drive_cycle(code, pie, sqe, 1'b1, req);
      for (int g = 0; g < gap; g++) drive_cycle(code, pie, sqe, 1'b0, req);
    end
  endtask

  // Monitor: compares one expected item per cycle, just after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        if (pf_evt !== e.pf || sqw_pulse !== e.sq) begin
          n_fail++;
          $display("FAIL %s: pf_evt=%b sqw_pulse=%b expected pf_evt=%b sqw_pulse=%b",
                   e.req, pf_evt, sqw_pulse, e.pf, e.sq);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (pf_evt !== 1'b0 || sqw_pulse !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: pf_evt=%b sqw_pulse=%b expected 0 0", pf_evt, sqw_pulse);
    end
    @(negedge clk);
    rst = 1'b0;
    mcnt = '0;

    run(4'd3, 1'b1, 1'b0, 20, 0, "R1 R3 period 4 after reset");
    run(4'd6, 1'b1, 1'b0, 100, 0, "R3 period 32");
    run(4'd1, 1'b1, 1'b0, 300, 0, "R4 code 1 aliased to 128");
    run(4'd2, 1'b1, 1'b0, 600, 0, "R4 code 2 aliased to 256");
    run(4'd0, 1'b1, 1'b1, 300, 0, "R2 code 0 stops tick");
    run(4'd3, 1'b0, 1'b0, 50, 0, "R5 both enables off");
    run(4'd3, 1'b1, 1'b0, 21, 0, "R5 R8 count kept running");
    run(4'd4, 1'b0, 1'b1, 64, 0, "R7 square-wave only");
    run(4'd4, 1'b1, 1'b1, 64, 0, "R6 R7 both enables");
    run(4'd5, 1'b1, 1'b0, 64, 0, "R6 periodic only");
    run(4'd8, 1'b1, 1'b1, 10, 0, "R8 before rate change");
    run(4'd3, 1'b1, 1'b1, 30, 0, "R8 new rate aligned to count");
    run(4'd3, 1'b1, 1'b0, 40, 2, "R9 strobes with gaps");
    run(4'd15, 1'b1, 1'b1, 16500, 0, "R3 code 15 period 16384");

    @(negedge clk);
    tb_tick = 1'b0;
    while (exp_q.size() > 0) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule